// File: doc/BRIEF.md
# Record-Buffered Programmed I/O Unit

This block sequences four byte-wide I/O commands between a CPU, memory and a small set of record-oriented peripherals. A command picks the current device, copies one byte from that device into memory, copies one byte from memory to that device, or ends the current record on that device. The unit drives the memory address, write data and the read and write strobes. It drives a one-hot device select, a request strobe with a direction bit, and a feed strobe. Each device answers with a ready pulse, a data byte, an end-of-record line and an out-of-input line.

Two peripherals live inside the top module, so the unit can be tested on its own. Device 1 is a card reader with a one-record buffer. It refills the whole record from its deck only when the buffer is empty, one byte per cycle, and then hands out one byte per request. Device 2 is a line printer. It latches each byte it is sent and feeds on its own once a line is full. A read request that finds the reader empty with no cards left halts the unit for good.

Top module: `rbio_unit`

## Requirements
- R1: After reset the unit is idle (`busy`=0, `done`=0, `mem_we`=0, `halted`=0, `dev_err`=0). The device ID is 0, so `dev_sel` is all zero.
- R2: Op code 0 (select) loads the low DIDW bits of `cmd_arg` into the device ID. `dev_sel[i]` is then high only when the ID equals i+1, and it stays until the next select.
- R3: A select of an ID with no device (anything but 1 or 2) sets `dev_err`. A select of an attached device clears it.
- R4: Op code 1 (input) from the reader writes one byte to memory at `cmd_arg`. Byte k (0..RECLEN-1) of card c (cards counted from 0) equals (c*29 + k*3 + 0x5A) mod 256. Bytes come out in order with none skipped.
- R5: An input that finds the reader buffer empty takes exactly RECLEN+1 cycles longer, from acceptance to `done`, than an input served from a full buffer.
- R6: `rec_end` is high together with `done` of the input that delivers the last byte of a record, and low for every other input.
- R7: Op code 3 (feed) to the reader drops the rest of the buffered record and raises `rec_end`. The next input returns byte 0 of the next card.
- R8: Op code 2 (output) to the printer reads memory at `cmd_arg` and presents that byte on `prn_data` with a one-cycle `prn_strobe`.
- R9: On the LINE_LEN-th byte since the last feed, the printer pulses `prn_feed` by itself, and that output's `done` comes with `rec_end`.
- R10: Feed to the printer pulses `prn_feed` once, raises `rec_end` and restarts the column count.
- R11: While no device is selected, an input writes 0x00 to its address, and output and feed raise no device request or feed strobe.
- R12: An input that finds the reader empty when the number of cards used equals `deck_cards` raises `halted`. It makes no memory write and no `done`. The unit then ignores all commands until reset.
- R13: `done` is a single-cycle pulse at the end of each command. A command offered while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered; accepted when not busy |
| cmd_op | input | 2 | 0 select, 1 input, 2 output, 3 feed |
| cmd_arg | input | AW | Memory address, or device ID in the low bits |
| busy | output | 1 | A command is in progress or the unit is halted |
| done | output | 1 | One-cycle end-of-command pulse |
| rec_end | output | 1 | End of record reported with `done` |
| dev_err | output | 1 | Selected ID has no device |
| halted | output | 1 | Reader ran out of cards |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data is expected the next cycle |
| mem_rdata | input | 8 | Memory read data |
| deck_cards | input | 8 | Cards loaded in the reader hopper |
| dev_sel | output | NDEV | One-hot device select |
| dev_req | output | 1 | Transfer request to the selected device |
| dev_wr | output | 1 | Request direction, 1 = to the device |
| dev_feed | output | 1 | Feed request to the selected device |
| prn_data | output | 8 | Last byte latched by the printer |
| prn_strobe | output | 1 | Printer accepted a byte |
| prn_feed | output | 1 | Printer performed a line feed |

## Verification
The hardest states to reach are the refill that happens in the middle of a run and the out-of-cards halt. Both depend on how many bytes the reader has already handed out and how many cards it has used, and none of that shows at the ports. The bench keeps its own model of the reader pointer, the cards used and the printer column, and runs a long random mix of selects, inputs, outputs and feeds through it. It also offers a select to a missing device in the middle of a refill stall. At the end it lowers `deck_cards` to the modelled card count, drains the buffer with a feed, and issues one more input to force the halt.

// File: rtl/rbio_pkg.sv
package rbio_pkg;

    localparam int NDEV = 2;
    localparam int ID_READER  = 1;
    localparam int ID_PRINTER = 2;

    typedef enum logic [1:0] {
        OP_SEL  = 2'd0,
        OP_IN   = 2'd1,
        OP_OUT  = 2'd2,
        OP_FEED = 2'd3
    } op_e;

    typedef struct packed {
        logic       ready;
        logic       eor;
        logic       empty;
        logic [7:0] data;
    } dev_rsp_t;

    function automatic logic [7:0] card_byte(input logic [7:0] card, input int idx);
        logic [7:0] ix;
        ix = 8'(idx);
        return 8'(card * 8'd29 + ix * 8'd3 + 8'h5A);
    endfunction

endpackage

// File: rtl/rbio_reader.sv
module rbio_reader
    import rbio_pkg::*;
#(
    parameter int RECLEN = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       req,
    input  logic       wr,
    input  logic       feed,
    input  logic [7:0] deck_cards,
    output dev_rsp_t   rsp
);
    localparam int PW = (RECLEN > 1) ? $clog2(RECLEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(RECLEN - 1);

    typedef enum logic { RD_IDLE, RD_FILL } rd_st_e;

    rd_st_e          st;
    logic [7:0]      rec_buf [RECLEN];
    logic [PW-1:0]   ptr;
    logic [PW-1:0]   fidx;
    logic            full;
    logic [7:0]      cards_used;
    dev_rsp_t        rsp_q;

    assign rsp = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= RD_IDLE;
            ptr        <= '0;
            fidx       <= '0;
            full       <= 1'b0;
            cards_used <= '0;
            rsp_q      <= '0;
        end else begin
            rsp_q.ready <= 1'b0;
            rsp_q.eor   <= 1'b0;
            rsp_q.empty <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (sel && !rsp_q.ready) begin
                        if (feed) begin
                            full        <= 1'b0;
                            ptr         <= '0;
                            rsp_q.ready <= 1'b1;
                            rsp_q.eor   <= 1'b1;
                        end else if (req && wr) begin
                            rsp_q.ready <= 1'b1;
                        end else if (req) begin
                            if (full) begin
                                rsp_q.data  <= rec_buf[ptr];
                                rsp_q.eor   <= (ptr == LAST);
                                rsp_q.ready <= 1'b1;
                                if (ptr == LAST) begin
                                    full <= 1'b0;
                                    ptr  <= '0;
                                end else begin
                                    ptr <= ptr + 1'b1;
                                end
                            end else if (cards_used >= deck_cards) begin
                                rsp_q.empty <= 1'b1;
                                rsp_q.ready <= 1'b1;
                            end else begin
                                st   <= RD_FILL;
                                fidx <= '0;
                            end
                        end
                    end
                end
                RD_FILL: begin
                    rec_buf[fidx] <= card_byte(cards_used, int'(fidx));
                    if (fidx == LAST) begin
                        full       <= 1'b1;
                        ptr        <= '0;
                        cards_used <= cards_used + 8'd1;
                        st         <= RD_IDLE;
                    end else begin
                        fidx <= fidx + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rbio_printer.sv
module rbio_printer
    import rbio_pkg::*;
#(
    parameter int LINE_LEN = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       req,
    input  logic       wr,
    input  logic       feed,
    input  logic [7:0] wdata,
    output dev_rsp_t   rsp,
    output logic [7:0] prn_data,
    output logic       prn_strobe,
    output logic       prn_feed
);
    localparam int CW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam logic [CW-1:0] LAST_COL = CW'(LINE_LEN - 1);

    logic [CW-1:0] col;
    dev_rsp_t      rsp_q;

    assign rsp = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col        <= '0;
            rsp_q      <= '0;
            prn_data   <= '0;
            prn_strobe <= 1'b0;
            prn_feed   <= 1'b0;
        end else begin
            rsp_q.ready <= 1'b0;
            rsp_q.eor   <= 1'b0;
            rsp_q.empty <= 1'b0;
            prn_strobe  <= 1'b0;
            prn_feed    <= 1'b0;
            if (sel && !rsp_q.ready) begin
                if (feed) begin
                    prn_feed    <= 1'b1;
                    col         <= '0;
                    rsp_q.eor   <= 1'b1;
                    rsp_q.ready <= 1'b1;
                end else if (req && wr) begin
                    prn_data    <= wdata;
                    prn_strobe  <= 1'b1;
                    rsp_q.ready <= 1'b1;
                    if (col == LAST_COL) begin
                        prn_feed  <= 1'b1;
                        rsp_q.eor <= 1'b1;
                        col       <= '0;
                    end else begin
                        col <= col + 1'b1;
                    end
                end else if (req) begin
                    rsp_q.data  <= 8'h00;
                    rsp_q.ready <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rbio_seq.sv
module rbio_seq
    import rbio_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DIDW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_arg,
    output logic            busy,
    output logic            done,
    output logic            rec_end,
    output logic            dev_err,
    output logic            halted,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    output logic            mem_re,
    input  logic [7:0]      mem_rdata,
    output logic [DIDW-1:0] did,
    output logic            dev_req,
    output logic            dev_wr,
    output logic            dev_feed,
    output logic [7:0]      dev_wdata,
    input  dev_rsp_t        rsp
);
    typedef enum logic [3:0] {
        S_IDLE, S_IREQ, S_WR, S_ORD, S_OWT, S_OREQ, S_FREQ, S_FIN, S_HALT
    } seq_st_e;

    seq_st_e        st;
    logic [AW-1:0]  addr_q;
    logic [7:0]     data_q;
    logic           eor_q;
    logic           attached;
    logic [DIDW-1:0] new_did;
    logic           new_attached;

    function automatic logic is_dev(input logic [DIDW-1:0] id);
        return (int'(id) >= 1) && (int'(id) <= NDEV);
    endfunction

    assign attached     = is_dev(did);
    assign new_did      = cmd_arg[DIDW-1:0];
    assign new_attached = is_dev(new_did);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            did     <= '0;
            dev_err <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            eor_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (cmd_valid) begin
                        addr_q <= cmd_arg;
                        eor_q  <= 1'b0;
                        case (op_e'(cmd_op))
                            OP_SEL: begin
                                did     <= new_did;
                                dev_err <= !new_attached;
                                st      <= S_FIN;
                            end
                            OP_IN: begin
                                if (attached) begin
                                    st <= S_IREQ;
                                end else begin
                                    data_q <= 8'h00;
                                    st     <= S_WR;
                                end
                            end
                            OP_OUT:  st <= S_ORD;
                            OP_FEED: st <= attached ? S_FREQ : S_FIN;
                            default: st <= S_FIN;
                        endcase
                    end
                end
                S_IREQ: begin
                    if (rsp.ready) begin
                        if (rsp.empty) begin
                            st <= S_HALT;
                        end else begin
                            data_q <= rsp.data;
                            eor_q  <= rsp.eor;
                            st     <= S_WR;
                        end
                    end
                end
                S_WR:  st <= S_FIN;
                S_ORD: st <= S_OWT;
                S_OWT: begin
                    data_q <= mem_rdata;
                    st     <= attached ? S_OREQ : S_FIN;
                end
                S_OREQ, S_FREQ: begin
                    if (rsp.ready) begin
                        eor_q <= rsp.eor;
                        st    <= S_FIN;
                    end
                end
                S_FIN:  st <= S_IDLE;
                S_HALT: st <= S_HALT;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_FIN);
        rec_end   = (st == S_FIN) && eor_q;
        halted    = (st == S_HALT);
        mem_addr  = addr_q;
        mem_wdata = data_q;
        mem_we    = (st == S_WR);
        mem_re    = (st == S_ORD);
        dev_req   = (st == S_IREQ) || (st == S_OREQ);
        dev_wr    = (st == S_OREQ);
        dev_feed  = (st == S_FREQ);
        dev_wdata = data_q;
    end

endmodule

// File: rtl/rbio_unit.sv
module rbio_unit
    import rbio_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DIDW     = 2,
    parameter int RECLEN   = 24,
    parameter int LINE_LEN = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_arg,
    output logic            busy,
    output logic            done,
    output logic            rec_end,
    output logic            dev_err,
    output logic            halted,
    output logic [AW-1:0]   mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            mem_we,
    output logic            mem_re,
    input  logic [7:0]      mem_rdata,
    input  logic [7:0]      deck_cards,
    output logic [NDEV-1:0] dev_sel,
    output logic            dev_req,
    output logic            dev_wr,
    output logic            dev_feed,
    output logic [7:0]      prn_data,
    output logic            prn_strobe,
    output logic            prn_feed
);
    logic [DIDW-1:0] did;
    logic [7:0]      dev_wdata;
    dev_rsp_t        rsp_mux;
    dev_rsp_t        rsp_dev [NDEV];

    rbio_seq #(.AW(AW), .DIDW(DIDW)) seq_i (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .busy(busy), .done(done), .rec_end(rec_end),
        .dev_err(dev_err), .halted(halted),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .did(did), .dev_req(dev_req), .dev_wr(dev_wr),
        .dev_feed(dev_feed), .dev_wdata(dev_wdata), .rsp(rsp_mux)
    );

    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign dev_sel[i] = (int'(did) == i + 1);
    end

    always_comb begin
        rsp_mux = '0;
        for (int i = 0; i < NDEV; i++) begin
            if (dev_sel[i]) rsp_mux = rsp_mux | rsp_dev[i];
        end
    end

    rbio_reader #(.RECLEN(RECLEN)) reader_i (
        .clk(clk), .rst(rst),
        .sel(dev_sel[ID_READER-1]), .req(dev_req), .wr(dev_wr),
        .feed(dev_feed), .deck_cards(deck_cards),
        .rsp(rsp_dev[ID_READER-1])
    );

    rbio_printer #(.LINE_LEN(LINE_LEN)) printer_i (
        .clk(clk), .rst(rst),
        .sel(dev_sel[ID_PRINTER-1]), .req(dev_req), .wr(dev_wr),
        .feed(dev_feed), .wdata(dev_wdata),
        .rsp(rsp_dev[ID_PRINTER-1]),
        .prn_data(prn_data), .prn_strobe(prn_strobe), .prn_feed(prn_feed)
    );

endmodule

// File: rtl/rbio_unit_sva.sv
module rbio_unit_sva
    import rbio_pkg::*;
#(
    parameter int AW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            done,
    input logic            halted,
    input logic            dev_err,
    input logic            mem_we,
    input logic [7:0]      mem_wdata,
    input logic [NDEV-1:0] dev_sel,
    input logic            dev_req,
    input logic            dev_wr,
    input logic            dev_feed,
    input logic            prn_strobe
);
    p_done_single_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !done && !mem_we));

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));

    p_no_req_unattached_r11: assert property (@(posedge clk) disable iff (rst)
        (dev_req || dev_feed) |-> (dev_sel != '0));

    p_zero_write_on_err_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_we && dev_err) |-> (mem_wdata == 8'h00));

    p_strobe_after_req_r8: assert property (@(posedge clk) disable iff (rst)
        prn_strobe |-> $past(dev_req && dev_wr));
endmodule

bind rbio_unit rbio_unit_sva #(.AW(AW)) sva_i (
    .clk(clk), .rst(rst), .done(done), .halted(halted), .dev_err(dev_err),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .dev_sel(dev_sel),
    .dev_req(dev_req), .dev_wr(dev_wr), .dev_feed(dev_feed),
    .prn_strobe(prn_strobe)
);

// File: tb/rbio_unit_tb.sv
module rbio_unit_tb_top;
    localparam int AW = 8;
    localparam int RECLEN = 24;
    localparam int LINE_LEN = 24;

    logic clk = 0;
    logic rst = 1;
    logic cmd_valid = 0;
    logic [1:0] cmd_op = 0;
    logic [AW-1:0] cmd_arg = 0;
    logic busy, done, rec_end, dev_err, halted;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic mem_we, mem_re;
    logic [7:0] mem_rdata = 0;
    logic [7:0] deck_cards = 8'd255;
    logic [1:0] dev_sel;
    logic dev_req, dev_wr, dev_feed;
    logic [7:0] prn_data;
    logic prn_strobe, prn_feed;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ram [256];
    int strobe_cnt = 0;
    int feed_cnt = 0;
    int req_cnt = 0;
    int we_cnt = 0;

    // model state
    int m_did = 0;
    bit m_full = 0;
    int m_ptr = 0;
    int m_cards = 0;
    int m_card_cur = 0;
    int m_col = 0;

    always #5 clk = ~clk;

    rbio_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .busy(busy), .done(done), .rec_end(rec_end),
        .dev_err(dev_err), .halted(halted), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .deck_cards(deck_cards), .dev_sel(dev_sel),
        .dev_req(dev_req), .dev_wr(dev_wr), .dev_feed(dev_feed),
        .prn_data(prn_data), .prn_strobe(prn_strobe), .prn_feed(prn_feed)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] = mem_wdata;
            we_cnt++;
        end
        if (mem_re) mem_rdata <= ram[mem_addr];
        if (prn_strobe) strobe_cnt++;
        if (prn_feed) feed_cnt++;
        if (dev_req || dev_feed) req_cnt++;
    end

    function automatic logic [7:0] exp_byte(input int card, input int k);
        return 8'((card * 29 + k * 3 + 'h5A) % 256);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #2000000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    // issue a command and wait for done; lat counts negedges from acceptance
    task automatic do_cmd(input int op, input int arg, output int lat, output bit re);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_arg = AW'(arg);
        @(negedge clk);
        cmd_valid = 0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        re = rec_end;
        check("R13 done seen", int'(done), 1);
        @(negedge clk);
        check("R13 done single cycle", int'(done), 0);
    endtask

    // model-driven ops
    task automatic op_sel(input int id);
        int lat; bit re;
        do_cmd(0, id, lat, re);
        m_did = id & 3;
        check("R3 dev_err", int'(dev_err), (m_did == 1 || m_did == 2) ? 0 : 1);
        check("R2 dev_sel", int'(dev_sel),
              m_did == 1 ? 1 : (m_did == 2 ? 2 : 0));
    endtask

    task automatic op_in(input int addr);
        int lat; bit re; int exp; bit exp_re;
        exp = 0; exp_re = 0;
        if (m_did == 1) begin
            if (!m_full) begin
                m_card_cur = m_cards; m_cards++; m_ptr = 0; m_full = 1;
            end
            exp = exp_byte(m_card_cur, m_ptr);
            exp_re = (m_ptr == RECLEN - 1);
            m_ptr++;
            if (m_ptr == RECLEN) begin m_full = 0; m_ptr = 0; end
        end
        ram[addr] = 8'hC3;
        do_cmd(1, addr, lat, re);
        check(m_did == 1 ? "R4 input byte" : "R11 input zero", int'(ram[addr]), exp);
        check("R6 rec_end on input", int'(re), int'(exp_re));
    endtask

    task automatic op_out(input int addr, input int val);
        int lat; bit re; int s0, f0; bit exp_f;
        ram[addr] = 8'(val);
        s0 = strobe_cnt; f0 = feed_cnt; exp_f = 0;
        if (m_did == 2) begin
            m_col++;
            if (m_col == LINE_LEN) begin m_col = 0; exp_f = 1; end
        end
        do_cmd(2, addr, lat, re);
        check("R8 strobe count", strobe_cnt - s0, m_did == 2 ? 1 : 0);
        if (m_did == 2) check("R8 printer byte", int'(prn_data), val & 255);
        check("R9 auto feed", feed_cnt - f0, int'(exp_f));
        check("R9 rec_end on output", int'(re), int'(exp_f));
    endtask

    task automatic op_feed();
        int lat; bit re; int f0;
        f0 = feed_cnt;
        if (m_did == 1) begin m_full = 0; m_ptr = 0; end
        if (m_did == 2) m_col = 0;
        do_cmd(3, 0, lat, re);
        check("R10 feed strobe", feed_cnt - f0, m_did == 2 ? 1 : 0);
        check("R7 rec_end on feed", int'(re), (m_did == 1 || m_did == 2) ? 1 : 0);
    endtask

    initial begin
        int lat_a, lat_b, r0, w0;
        bit re;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 mem_we", int'(mem_we), 0);
        check("R1 halted", int'(halted), 0);
        check("R1 dev_err", int'(dev_err), 0);
        check("R1 dev_sel", int'(dev_sel), 0);

        // R11 with no device selected
        op_sel(0);
        r0 = req_cnt;
        op_in(5);
        op_out(6, 8'h77);
        op_feed();
        check("R11 no device request", req_cnt - r0, 0);
        op_sel(3);
        op_sel(1);

        // R5 refill versus buffered latency
        ram[10] = 0;
        m_card_cur = m_cards; m_cards++; m_full = 1; m_ptr = 1;
        do_cmd(1, 10, lat_a, re);
        check("R4 first byte", int'(ram[10]), exp_byte(m_card_cur, 0));
        do_cmd(1, 11, lat_b, re);
        m_ptr = 2;
        check("R4 second byte", int'(ram[11]), exp_byte(m_card_cur, 1));
        check("R5 refill extra cycles", lat_a - lat_b, RECLEN + 1);

        // R7 feed drops rest; R13 command offered while busy ignored
        op_feed();
        m_card_cur = m_cards; m_cards++; m_full = 1; m_ptr = 1;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd1; cmd_arg = 8'd12;
        @(negedge clk);
        cmd_op = 2'd0; cmd_arg = 8'd3;
        @(negedge clk);
        cmd_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check("R7 next card byte 0", int'(ram[12]), exp_byte(m_card_cur, 0));
        check("R13 busy select ignored err", int'(dev_err), 0);
        check("R13 busy select ignored sel", int'(dev_sel), 1);

        // R6 drain the record
        for (int k = 1; k < RECLEN; k++) op_in(20 + k);

        // R8/R9 full printer line, then R10
        op_sel(2);
        for (int k = 0; k < LINE_LEN; k++) op_out(100 + k, $urandom & 255);
        op_out(50, 8'hA5);
        op_feed();
        op_in(60);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int c;
            c = $urandom % 10;
            if (c == 0) op_sel(($urandom % 4));
            else if (c < 5) op_in(128 + ($urandom % 64));
            else if (c < 8) op_out(192 + ($urandom % 32), $urandom & 255);
            else op_feed();
        end

        // R12 out of cards
        op_sel(1);
        op_feed();
        deck_cards = 8'(m_cards);
        ram[9] = 8'hAB;
        w0 = we_cnt;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd1; cmd_arg = 8'd9;
        @(negedge clk);
        cmd_valid = 0;
        re = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done) re = 1;
        end
        check("R12 halted", int'(halted), 1);
        check("R12 no done", int'(re), 0);
        check("R12 no write", we_cnt - w0, 0);
        check("R12 memory kept", int'(ram[9]), 8'hAB);
        cmd_valid = 1; cmd_op = 2'd0; cmd_arg = 8'd2;
        repeat (3) @(negedge clk);
        cmd_valid = 0;
        @(negedge clk);
        check("R12 select ignored", int'(dev_sel), 1);
        check("R12 still halted", int'(halted), 1);
        summary();
    end
endmodule